// File: doc/BRIEF.md
# Privilege Guard

This block sits beside a small processor core and decides, cycle by cycle, whether the core runs with user rights or kernel rights. It watches the program fetch address and program overlay, every data memory access with its data overlay, interrupt entries with their vector address, and return-from-interrupt events. The only way into kernel rights is one fixed entry point. Kernel rights end as soon as execution leaves kernel program space.

The guard keeps one saved kernel context. When an interrupt pre-empts kernel code, the guard records the interrupted address and overlay and raises the nesting level. The handler may call into the kernel once more. A return from the handler has to land exactly on the saved point.

Any breach of these rules produces a one-cycle chip reset pulse and a wipe request. The same pulse returns the guard to user rights with nesting level zero. While kernel code flags a sensitive phase, the guard masks interrupts.

Top module: `kguard_top`

## Requirements
- R1: After synchronous reset, `priv` is 0 (user), `nest` is 0, and `chip_rst` and `wipe_req` are 0.
- R2: In user mode, a fetch of address 0x2000 with program overlay 0x000F sets `priv` to 1 (kernel) from the next cycle on. The nesting level is unchanged.
- R3: In user mode, a fetch is a violation when its address is in 0x2000..0x3FFF and its program overlay is in 0x000C..0x000F, unless it is the entry point of R2. Any other address/overlay pair, for example 0x2400 with overlay 0x0001, is legal.
- R4: In user mode, a data access is a violation when its address is below 0x1800 and the data overlay is 0x000F. A data access at 0x1800 or above, or with any other overlay, is legal.
- R5: A violation in cycle t drives `chip_rst` and `wipe_req` high during cycle t+1 only, unless a new violation occurs. In that same cycle `priv` is 0 and `nest` is 0, and the saved context is discarded.
- R6: In kernel mode, a fetch outside kernel program space (address 0x2000..0x3FFF with overlay 0x000C..0x000F) returns `priv` to 0 without changing `nest`. Data accesses never violate in kernel mode.
- R7: An unmasked interrupt taken in kernel mode at `nest` 0 has these effects:
  - It saves the fetch address and overlay presented in that cycle.
  - It sets `nest` to 1.
  - It sets `priv` to 0 when the vector lies outside kernel program space.
  - The fetch presented in that cycle is not otherwise evaluated.
- R8: A fetch flagged with `rti` in user mode while `nest` is 1 returns to the kernel. When the fetch equals the saved address and overlay, `priv` becomes 1 and `nest` becomes 0. Any other target is a violation.
- R9: An interrupt taken while `priv` is 1 and `nest` is 1 is a violation when its vector lies outside kernel program space.
- R10: A fetch of the entry point while `priv` is 1 and `nest` is 1 is a violation.
- R11: `irq_block` equals kernel mode AND `sens_phase`. An interrupt entry signalled while `irq_block` is 1 leaves `priv`, `nest` and the reset outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | 14 | Program fetch address |
| pm_ovl | input | 16 | Program overlay value |
| dm_valid | input | 1 | A data memory access is presented this cycle |
| dm_addr | input | 14 | Data memory address |
| dm_ovl | input | 16 | Data overlay value |
| irq_take | input | 1 | Core enters an interrupt this cycle |
| irq_vec | input | 14 | Vector address of that interrupt |
| rti | input | 1 | The fetch this cycle is the target of a return from interrupt |
| sens_phase | input | 1 | Kernel code is moving sensitive data |
| priv | output | 1 | 1 = kernel mode, 0 = user mode |
| nest | output | 1 | 1 while a pre-empted kernel context is saved |
| irq_block | output | 1 | Interrupts must be held off |
| chip_rst | output | 1 | One-cycle chip reset on violation |
| wipe_req | output | 1 | One-cycle erase request on violation |

## Verification
A wrong mode bit is visible on `priv` one cycle after the fetch that should have moved it. Before long it also shows as a spurious or missing `chip_rst`: a protected fetch or data access follows, and the pulse comes one cycle after that access. A corrupted saved context stays hidden until the handler returns; the flaw then appears as a reset where the return should be accepted, or as kernel rights granted on a wrong target. A wrong nesting level shows on `nest` at once and decides whether a second entry or a user-vector interrupt resets the chip.

// File: rtl/kguard_pkg.sv
package kguard_pkg;

    localparam int ADDR_W = 14;
    localparam int OVL_W  = 16;

    // kernel program space: upper half of the program page with overlays C..F
    localparam logic [ADDR_W-1:0] KPROG_LO   = ADDR_W'('h2000);
    localparam logic [OVL_W-1:0]  KOVL_LO    = OVL_W'('h000C);
    localparam logic [OVL_W-1:0]  KOVL_HI    = OVL_W'('h000F);
    // the single legal way in
    localparam logic [ADDR_W-1:0] ENTRY_ADDR = ADDR_W'('h2000);
    localparam logic [OVL_W-1:0]  ENTRY_OVL  = OVL_W'('h000F);
    // protected data window
    localparam logic [ADDR_W-1:0] KDATA_END  = ADDR_W'('h1800);
    localparam logic [OVL_W-1:0]  KDATA_OVL  = OVL_W'('h000F);

    typedef enum logic {
        PRIV_USER = 1'b0,
        PRIV_KERN = 1'b1
    } priv_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [OVL_W-1:0]  ovl;
    } kpoint_t;

    typedef struct packed {
        logic entry;     // fetch hits the entry point
        logic kspace;    // fetch lies in kernel program space
        logic pm_bad;    // fetch is forbidden to user code
        logic dm_bad;    // data access is forbidden to user code
        logic vec_user;  // interrupt vector lies outside kernel space
    } kclass_t;

    // the top of the window is the top of the address range, so only the
    // lower bound needs a compare
    function automatic logic in_kprog(input logic [ADDR_W-1:0] a,
                                      input logic [OVL_W-1:0]  o);
        return (a >= KPROG_LO) && (o >= KOVL_LO) && (o <= KOVL_HI);
    endfunction

endpackage

// File: rtl/kguard_decode.sv
module kguard_decode
    import kguard_pkg::*;
(
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [OVL_W-1:0]  f_ovl,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [OVL_W-1:0]  d_ovl,
    input  logic [ADDR_W-1:0] v_addr,
    output kclass_t           cls
);

    always_comb begin
        cls.kspace   = in_kprog(f_addr, f_ovl);
        cls.entry    = (f_addr == ENTRY_ADDR) && (f_ovl == ENTRY_OVL);
        cls.pm_bad   = cls.kspace && !cls.entry;
        cls.dm_bad   = (d_addr < KDATA_END) && (d_ovl == KDATA_OVL);
        // a vector is fetched under the overlay currently in force
        cls.vec_user = !in_kprog(v_addr, f_ovl);
    end

endmodule

// File: rtl/kguard_ctrl.sv
module kguard_ctrl
    import kguard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  kclass_t cls,
    input  kpoint_t here,
    input  logic    fetch_valid,
    input  logic    dm_valid,
    input  logic    irq_take,
    input  logic    rti,
    input  logic    sens_phase,
    output priv_e   priv_q,
    output logic    nest_q,
    output logic    viol_q,
    output logic    irq_block
);

    kpoint_t save_q, save_d;
    priv_e   priv_d;
    logic    nest_d;
    logic    viol;
    logic    irq_go;

    always_comb begin
        irq_block = (priv_q == PRIV_KERN) && sens_phase;
        irq_go    = irq_take && !irq_block;
        priv_d    = priv_q;
        nest_d    = nest_q;
        save_d    = save_q;
        viol      = 1'b0;

        if (irq_go) begin
            if (priv_q == PRIV_KERN) begin
                if (nest_q) begin
                    if (cls.vec_user) viol = 1'b1;
                end else begin
                    save_d = here;
                    nest_d = 1'b1;
                    if (cls.vec_user) priv_d = PRIV_USER;
                end
            end
        end else if (fetch_valid) begin
            if (priv_q == PRIV_USER) begin
                if (rti && nest_q) begin
                    if (here == save_q) begin
                        priv_d = PRIV_KERN;
                        nest_d = 1'b0;
                    end else begin
                        viol = 1'b1;
                    end
                end else if (cls.entry) begin
                    priv_d = PRIV_KERN;
                end else if (cls.pm_bad) begin
                    viol = 1'b1;
                end
            end else begin
                if (cls.entry && nest_q) begin
                    viol = 1'b1;
                end else if (!cls.kspace) begin
                    priv_d = PRIV_USER;
                end
            end
        end

        if (dm_valid && (priv_q == PRIV_USER) && cls.dm_bad) viol = 1'b1;

        if (viol) begin
            priv_d = PRIV_USER;
            nest_d = 1'b0;
            save_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q <= PRIV_USER;
            nest_q <= 1'b0;
            save_q <= '0;
            viol_q <= 1'b0;
        end else begin
            priv_q <= priv_d;
            nest_q <= nest_d;
            save_q <= save_d;
            viol_q <= viol;
        end
    end

endmodule

// File: rtl/kguard_top.sv
module kguard_top
    import kguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [OVL_W-1:0]  pm_ovl,
    input  logic              dm_valid,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic [OVL_W-1:0]  dm_ovl,
    input  logic              irq_take,
    input  logic [ADDR_W-1:0] irq_vec,
    input  logic              rti,
    input  logic              sens_phase,
    output logic              priv,
    output logic              nest,
    output logic              irq_block,
    output logic              chip_rst,
    output logic              wipe_req
);

    kclass_t cls;
    kpoint_t here;
    priv_e   priv_q;
    logic    viol_q;

    assign here = '{addr: fetch_addr, ovl: pm_ovl};

    kguard_decode u_dec (
        .f_addr (fetch_addr),
        .f_ovl  (pm_ovl),
        .d_addr (dm_addr),
        .d_ovl  (dm_ovl),
        .v_addr (irq_vec),
        .cls    (cls)
    );

    kguard_ctrl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .here        (here),
        .fetch_valid (fetch_valid),
        .dm_valid    (dm_valid),
        .irq_take    (irq_take),
        .rti         (rti),
        .sens_phase  (sens_phase),
        .priv_q      (priv_q),
        .nest_q      (nest),
        .viol_q      (viol_q),
        .irq_block   (irq_block)
    );

    assign priv     = (priv_q == PRIV_KERN);
    assign chip_rst = viol_q;
    assign wipe_req = viol_q;

endmodule

// File: rtl/kguard_chk.sv
module kguard_chk
    import kguard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [OVL_W-1:0]  pm_ovl,
    input logic              dm_valid,
    input logic [ADDR_W-1:0] dm_addr,
    input logic [OVL_W-1:0]  dm_ovl,
    input logic              irq_take,
    input logic              irq_block,
    input logic              priv,
    input logic              nest,
    input logic              chip_rst
);

    logic at_entry, dm_prot;
    assign at_entry = fetch_valid && (fetch_addr == 14'h2000) && (pm_ovl == 16'h000F);
    assign dm_prot  = dm_valid && (dm_addr < 14'h1800) && (dm_ovl == 16'h000F);

    // R2: the fixed entry point grants kernel rights
    a_r2_entry: assert property (@(posedge clk) disable iff (rst)
        (!priv && !nest && at_entry && !irq_take && !dm_prot) |=> priv);

    // R2: kernel rights only ever rise right after a fetch
    a_r2_rise_after_fetch: assert property (@(posedge clk) disable iff (rst)
        $rose(priv) |-> $past(fetch_valid));

    // R4: protected data in user mode trips the reset
    a_r4_data_trip: assert property (@(posedge clk) disable iff (rst)
        (!priv && dm_prot) |=> chip_rst);

    // R5: the reset pulse comes with user mode and level zero
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        chip_rst |-> (!priv && !nest));

    // R10: a second entry while nested trips the reset
    a_r10_reentry: assert property (@(posedge clk) disable iff (rst)
        (priv && nest && at_entry && !irq_take) |=> chip_rst);

    // R11: a masked interrupt changes nothing
    a_r11_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_block && irq_take && !fetch_valid && !dm_valid) |=> (priv && $stable(nest) && !chip_rst));

endmodule

bind kguard_top kguard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .pm_ovl      (pm_ovl),
    .dm_valid    (dm_valid),
    .dm_addr     (dm_addr),
    .dm_ovl      (dm_ovl),
    .irq_take    (irq_take),
    .irq_block   (irq_block),
    .priv        (priv),
    .nest        (nest),
    .chip_rst    (chip_rst)
);

// File: tb/kguard_top_test.sv
module kguard_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [13:0] fetch_addr = '0;
    logic [15:0] pm_ovl = '0;
    logic        dm_valid = 1'b0;
    logic [13:0] dm_addr = '0;
    logic [15:0] dm_ovl = '0;
    logic        irq_take = 1'b0;
    logic [13:0] irq_vec = '0;
    logic        rti = 1'b0;
    logic        sens_phase = 1'b0;
    logic        priv, nest, irq_block, chip_rst, wipe_req;

    int vectors = 0;
    int miscompares = 0;

    typedef struct {
        logic  p;
        logic  n;
        logic  v;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    kguard_top uut (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .pm_ovl(pm_ovl),
        .dm_valid(dm_valid), .dm_addr(dm_addr), .dm_ovl(dm_ovl),
        .irq_take(irq_take), .irq_vec(irq_vec), .rti(rti), .sens_phase(sens_phase),
        .priv(priv), .nest(nest), .irq_block(irq_block),
        .chip_rst(chip_rst), .wipe_req(wipe_req)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // driver: one input cycle, expectation goes to the scoreboard
    task automatic cyc(input logic fv, input logic [13:0] fa, input logic [15:0] fo,
                       input logic dv, input logic [13:0] da, input logic [15:0] dov,
                       input logic it, input logic [13:0] iv, input logic r,
                       input logic ep, input logic en, input logic ev, input string tag);
        exp_t e;
        @(negedge clk);
        fetch_valid = fv; fetch_addr = fa; pm_ovl = fo;
        dm_valid = dv; dm_addr = da; dm_ovl = dov;
        irq_take = it; irq_vec = iv; rti = r;
        e.p = ep; e.n = en; e.v = ev; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic ep, en, ev, input string tag);
        cyc(0, '0, '0, 0, '0, '0, 0, '0, 0, ep, en, ev, tag);
    endtask
    task automatic fe(input logic [13:0] a, input logic [15:0] o, input logic ep, en, ev, input string tag);
        cyc(1, a, o, 0, '0, '0, 0, '0, 0, ep, en, ev, tag);
    endtask
    task automatic dm(input logic [13:0] a, input logic [15:0] o, input logic ep, en, ev, input string tag);
        cyc(0, '0, '0, 1, a, o, 0, '0, 0, ep, en, ev, tag);
    endtask
    task automatic irq(input logic [13:0] a, input logic [15:0] o, input logic [13:0] v,
                       input logic ep, en, ev, input string tag);
        cyc(1, a, o, 0, '0, '0, 1, v, 0, ep, en, ev, tag);
    endtask
    task automatic ret(input logic [13:0] a, input logic [15:0] o, input logic ep, en, ev, input string tag);
        cyc(1, a, o, 0, '0, '0, 0, '0, 1, ep, en, ev, tag);
    endtask

    // monitor: compare the registered outputs just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(priv, e.p, {e.tag, " priv"});
                chk(nest, e.n, {e.tag, " nest"});
                chk(chip_rst, e.v, {e.tag, " chip_rst"});
                chk(wipe_req, e.v, {e.tag, " wipe_req"});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(priv, 1'b0, "R1 reset priv");
        chk(nest, 1'b0, "R1 reset nest");
        chk(chip_rst, 1'b0, "R1 reset chip_rst");
        chk(wipe_req, 1'b0, "R1 reset wipe_req");
        rst = 1'b0;

        fe(14'h0100, 16'h0000, 0, 0, 0, "R3 low user fetch");
        fe(14'h2000, 16'h000E, 0, 0, 1, "R3 kernel page not at entry");
        idle(0, 0, 0, "R5 pulse lasts one cycle");
        fe(14'h2400, 16'h0001, 0, 0, 0, "R3 external page legal");
        fe(14'h2000, 16'h0000, 0, 0, 0, "R3 internal page legal");
        dm(14'h1000, 16'h000F, 0, 0, 1, "R4 protected data");
        dm(14'h1800, 16'h000F, 0, 0, 0, "R4 boundary data legal");
        dm(14'h0100, 16'h0000, 0, 0, 0, "R4 other overlay legal");
        ret(14'h0400, 16'h0000, 0, 0, 0, "R8 return with nothing saved");

        fe(14'h2000, 16'h000F, 1, 0, 0, "R2 entry");
        fe(14'h2500, 16'h000C, 1, 0, 0, "R6 stay in kernel space");
        dm(14'h0100, 16'h000F, 1, 0, 0, "R6 kernel data legal");

        sens_phase = 1'b1;
        irq(14'h2501, 16'h000C, 14'h0004, 1, 0, 0, "R11 masked irq ignored");
        #1 chk(irq_block, 1'b1, "R11 irq_block in sensitive phase");
        @(negedge clk);
        sens_phase = 1'b0;
        irq_take = 1'b0; fetch_valid = 1'b0;
        #1 chk(irq_block, 1'b0, "R11 irq_block released");

        irq(14'h2345, 16'h000D, 14'h0008, 0, 1, 0, "R7 irq saves context");
        fe(14'h0008, 16'h0000, 0, 1, 0, "R7 handler runs in user mode");
        fe(14'h2000, 16'h000F, 1, 1, 0, "R2 nested entry");
        fe(14'h2000, 16'h000F, 0, 0, 1, "R10 second entry while nested");
        idle(0, 0, 0, "R5 cleared after pulse");

        fe(14'h2000, 16'h000F, 1, 0, 0, "R2 entry again");
        irq(14'h2100, 16'h000C, 14'h0008, 0, 1, 0, "R7 save 2100");
        ret(14'h2101, 16'h000C, 0, 0, 1, "R8 wrong return address");
        fe(14'h2000, 16'h000F, 1, 0, 0, "R2 entry again");
        irq(14'h2100, 16'h000C, 14'h0008, 0, 1, 0, "R7 save 2100");
        ret(14'h2100, 16'h000D, 0, 0, 1, "R8 wrong return overlay");
        fe(14'h2000, 16'h000F, 1, 0, 0, "R2 entry again");
        irq(14'h2100, 16'h000C, 14'h0008, 0, 1, 0, "R7 save 2100");
        ret(14'h2100, 16'h000C, 1, 0, 0, "R8 exact return");
        fe(14'h0300, 16'h0000, 0, 0, 0, "R6 exit to user space");

        fe(14'h2000, 16'h000F, 1, 0, 0, "R2 entry again");
        irq(14'h2222, 16'h000E, 14'h0010, 0, 1, 0, "R7 save 2222");
        fe(14'h2000, 16'h000F, 1, 1, 0, "R2 nested entry");
        irq(14'h2223, 16'h000E, 14'h0010, 0, 0, 1, "R9 nested irq to user vector");

        fe(14'h2000, 16'h000F, 1, 0, 0, "R2 entry again");
        irq(14'h2222, 16'h000E, 14'h0010, 0, 1, 0, "R7 save 2222");
        fe(14'h2000, 16'h000F, 1, 1, 0, "R2 nested entry");
        fe(14'h0050, 16'h0000, 0, 1, 0, "R6 exit keeps level");
        ret(14'h2222, 16'h000E, 1, 0, 0, "R8 return after nested exit");
        fe(14'h0300, 16'h0000, 0, 0, 0, "R6 final exit");
        idle(0, 0, 0, "R5 quiet end");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule